// File: doc/BRIEF.md
# Dual-Channel Console Interrupt Controller

This block is the register-level front end of a two-channel serial console, channel A and channel B. A host reaches it through a small register bus with combinational read data. For each channel there is a status register, a holding register (reading returns the received byte, writing sends a byte) and a command register. A single shared address holds both the interrupt mask (when written) and the interrupt status (when read). One level interrupt line goes to the host.

Receive events come in on a per-channel arrival strobe, with a per-channel "character available" level and a receive byte. Transmit-ready interrupts are not driven by a shifter. They are synthesized from a periodic tick input and fire on every second tick. A status read on channel A is the acknowledge that drops the interrupt line. Baud generation, mode registers, counter/timer and output ports are not modelled. Their addresses read as zero and ignore writes.

Top module: `dual_console_irq`

## Requirements
- R1: After synchronous active-low reset, `irq` is 0, the interrupt mask is 0, the interrupt status (read at address 6) is 0x00 and the tick counter is at zero, so the second tick after reset is the first that can fire.
- R2: An arrival strobe on a channel while that channel's RX mask bit is set (A = bit 1, B = bit 5 of the mask) sets the matching status bit (A = 0x02, B = 0x20) and raises `irq` on the next clock. With the mask bit clear, the arrival changes neither the status nor `irq`.
- R3: A read of a channel status register (A at address 0, B at address 3) returns bit 0 equal to that channel's `rx_avail` input, bit 2 always 1, and all other bits 0.
- R4: A read of the channel A status register drops `irq` on the next clock. A read of the channel B status register leaves `irq` unchanged.
- R5: A read of a holding register (A at address 2, B at address 5) returns that channel's receive byte, clears that channel's RX status bit, and pulses that channel's `rx_pop` bit for one cycle after the access.
- R6: A write of a holding register puts the byte on that channel's transmit data output with a one-cycle `tx_valid` pulse (bit 0 = A, bit 1 = B) after the access, and clears only that channel's TX status bit (A = 0x01, B = 0x10).
- R7: Each tick advances a counter. On every second tick the counter returns to zero, and if mask bit 0 or mask bit 4 is set, both TX status bits (0x11) are set and `irq` is raised. With both TX mask bits clear, the counter still wraps but nothing is set.
- R8: A command register write (A at address 1, B at address 4) with data bit 3 set gives a one-cycle pulse on that channel's `flush` bit (bit 0 = A, bit 1 = B) after the access. With bit 3 clear there is no pulse.
- R9: A write to address 6 loads the 8-bit interrupt mask. A read of address 6 returns the interrupt status, not the mask.
- R10: Address 7 and reads of the command addresses return 0x00. Writes to address 7 change no state.
- R11: When a raise event (a masked arrival or a masked tick fire) meets a clear in the same cycle, the set wins. This holds both for `irq` against a channel A status read and for an RX status bit against a holding read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the access cycle |
| rx_avail | input | 2 | Character available level per channel (bit 0 = A) |
| rx_new | input | 2 | Character arrival strobe per channel |
| rx_data_a | input | 8 | Receive byte, channel A |
| rx_data_b | input | 8 | Receive byte, channel B |
| tick | input | 1 | Periodic tick for transmit-ready synthesis |
| tx_data_a | output | 8 | Last byte sent, channel A |
| tx_data_b | output | 8 | Last byte sent, channel B |
| tx_valid | output | 2 | Transmit strobe per channel |
| flush | output | 2 | Transmit-disable flush pulse per channel |
| rx_pop | output | 2 | Receive byte consumed pulse per channel |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench targets the asymmetric acknowledge. A design that cleared `irq` on a channel B status read, or that failed to clear it on a channel A read, fails the status-read scenarios. Tick counting is checked across a wrap with the TX mask clear, which catches a counter that is not advanced or not reset when nothing fires. It is also checked against an off-by-one divider that fires on the first tick. Mask and status sharing one address is checked by reading back after a mask write. A holding write on channel B is checked to clear only the B TX bit. Same-cycle raise and clear are driven together, which exposes a design that gives the acknowledge priority and loses an event.

// File: rtl/console_pkg.sv
// Package: console_pkg
// Shared widths, register indices and interrupt bit positions for the
// dual-channel console interrupt controller. Assumes two channels whose
// per-channel registers sit at consecutive indices from ch*CH_STRIDE.
package console_pkg;
    localparam int DW         = 8;
    localparam int AW         = 3;
    localparam int NCH        = 2;
    localparam int CH_STRIDE  = 3;

    // Per-channel offsets from the channel base index
    localparam int OFS_STAT   = 0;
    localparam int OFS_CMD    = 1;
    localparam int OFS_HOLD   = 2;

    // Shared interrupt register index
    localparam logic [AW-1:0] IDX_IRQ = 3'd6;

    // Interrupt bit positions: channel ch uses TX at 4*ch, RX at 4*ch+1
    localparam int BITS_PER_CH = 4;
    localparam int CMD_TXOFF_BIT = 3;
    localparam int STAT_RXAV_BIT = 0;
    localparam int STAT_TXRDY_BIT = 2;

    typedef struct packed {
        logic stat_rd;
        logic cmd_wr;
        logic hold_rd;
        logic hold_wr;
    } chan_acc_t;

    function automatic int tx_bit(input int ch);
        return ch * BITS_PER_CH;
    endfunction

    function automatic int rx_bit(input int ch);
        return ch * BITS_PER_CH + 1;
    endfunction
endpackage

// File: rtl/console_tick_pacer.sv
// Module: console_tick_pacer
// Counts tick pulses and produces a one-cycle fire on every TICK_DIV-th
// tick, wrapping the count at that point. Assumes TICK_DIV >= 2 and that
// tick is already synchronous to clk.
module console_tick_pacer #(
    parameter int TICK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic fire
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    // Fire combinationally on the tick that reaches the last count
    assign fire = tick && (cnt == LAST);

    // Advance the tick count, wrapping to zero on the firing tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

    AST_FIRE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R7
endmodule

// File: rtl/console_channel.sv
// Module: console_channel
// One console channel: forms its status and holding read values and
// registers its transmit, flush and receive-pop pulses. Assumes the
// access strobes are decoded one-hot by the parent.
module console_channel
    import console_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  chan_acc_t     acc,
    input  logic [DW-1:0] wdata,
    input  logic          rx_avail,
    input  logic [DW-1:0] rx_data,
    output logic [DW-1:0] stat_val,
    output logic [DW-1:0] hold_val,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    output logic          flush,
    output logic          rx_pop
);
    // Status word: receive-available mirrors the input, transmit always ready
    always_comb begin
        stat_val = '0;
        stat_val[STAT_RXAV_BIT]  = rx_avail;
        stat_val[STAT_TXRDY_BIT] = 1'b1;
    end

    // Holding read returns the byte presented by the receive path
    assign hold_val = rx_data;

    // Register the outgoing byte and the per-access pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data  <= '0;
            tx_valid <= 1'b0;
            flush    <= 1'b0;
            rx_pop   <= 1'b0;
        end else begin
            if (acc.hold_wr) tx_data <= wdata;
            tx_valid <= acc.hold_wr;
            flush    <= acc.cmd_wr && wdata[CMD_TXOFF_BIT];
            rx_pop   <= acc.hold_rd;
        end
    end

    AST_TX_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        acc.hold_wr |=> (tx_valid && tx_data == $past(wdata))); // R6
    AST_FLUSH_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> $past(acc.cmd_wr)); // R8
    AST_POP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        acc.hold_rd |=> rx_pop); // R5
endmodule

// File: rtl/console_irq_ctrl.sv
// Module: console_irq_ctrl
// Holds the shared interrupt mask and status and the interrupt line.
// Sets status bits from masked receive arrivals and tick fires, clears
// them on holding accesses; set wins over clear in the same cycle. The
// line drops only on the acknowledge input or reset.
module console_irq_ctrl
    import console_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_wr,
    input  logic [DW-1:0] wdata,
    input  logic [NCH-1:0] rx_new,
    input  logic [NCH-1:0] hold_rd,
    input  logic [NCH-1:0] hold_wr,
    input  logic          tx_fire,
    input  logic          ack,
    output logic [DW-1:0] mask,
    output logic [DW-1:0] isr,
    output logic          irq
);
    logic [DW-1:0]  isr_nxt;
    logic [NCH-1:0] rx_hit;
    logic           tx_hit;
    logic           raise;

    // Next status: clears from holding accesses first, then sets override
    always_comb begin
        isr_nxt = isr;
        tx_hit  = tx_fire && (mask[tx_bit(0)] || mask[tx_bit(1)]);
        for (int ch = 0; ch < NCH; ch++) begin
            rx_hit[ch] = rx_new[ch] && mask[rx_bit(ch)];
            if (hold_rd[ch]) isr_nxt[rx_bit(ch)] = 1'b0;
            if (hold_wr[ch]) isr_nxt[tx_bit(ch)] = 1'b0;
        end
        for (int ch = 0; ch < NCH; ch++) begin
            if (rx_hit[ch]) isr_nxt[rx_bit(ch)] = 1'b1;
            if (tx_hit)     isr_nxt[tx_bit(ch)] = 1'b1;
        end
        raise = (|rx_hit) || tx_hit;
    end

    // Update mask, status and interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            isr  <= '0;
            irq  <= 1'b0;
        end else begin
            if (mask_wr) mask <= wdata;
            isr <= isr_nxt;
            if (raise)    irq <= 1'b1;
            else if (ack) irq <= 1'b0;
        end
    end

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq ##1 irq |-> $past(|rx_new || tx_fire)); // R2
    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !(|rx_new) && !tx_fire) |=> !irq); // R4
    AST_RXA_MASKED_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_new[0] && mask[rx_bit(0)]) |=> isr[rx_bit(0)]); // R2
    AST_RXA_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_rd[0] && !rx_new[0]) |=> !isr[rx_bit(0)]); // R5
    AST_RXB_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !isr[rx_bit(1)] ##1 isr[rx_bit(1)] |-> $past(mask[rx_bit(1)])); // R2
endmodule

// File: rtl/dual_console_irq.sv
// Module: dual_console_irq
// Top of the dual-channel console interrupt controller: decodes the
// register bus, instantiates one channel per console and the shared
// interrupt controller and tick pacer, and muxes read data. Assumes a
// single-cycle access with combinational read data.
module dual_console_irq
    import console_pkg::*;
#(
    parameter int TICK_DIV = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_en,
    input  logic           reg_wr,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic [NCH-1:0] rx_avail,
    input  logic [NCH-1:0] rx_new,
    input  logic [DW-1:0]  rx_data_a,
    input  logic [DW-1:0]  rx_data_b,
    input  logic           tick,
    output logic [DW-1:0]  tx_data_a,
    output logic [DW-1:0]  tx_data_b,
    output logic [NCH-1:0] tx_valid,
    output logic [NCH-1:0] flush,
    output logic [NCH-1:0] rx_pop,
    output logic           irq
);
    chan_acc_t      acc      [NCH];
    logic [DW-1:0]  stat_val [NCH];
    logic [DW-1:0]  hold_val [NCH];
    logic [DW-1:0]  tx_arr   [NCH];
    logic [DW-1:0]  rx_arr   [NCH];
    logic [NCH-1:0] hold_rd_v;
    logic [NCH-1:0] hold_wr_v;
    logic [DW-1:0]  mask;
    logic [DW-1:0]  isr;
    logic           tx_fire;
    logic           rd_en;
    logic           wr_en;

    assign rd_en = reg_en && !reg_wr;
    assign wr_en = reg_en &&  reg_wr;

    assign rx_arr[0] = rx_data_a;
    assign rx_arr[1] = rx_data_b;
    assign tx_data_a = tx_arr[0];
    assign tx_data_b = tx_arr[1];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam logic [AW-1:0] BASE = AW'(g * CH_STRIDE);

        // Decode this channel's register accesses
        always_comb begin
            acc[g].stat_rd = rd_en && (reg_addr == BASE + AW'(OFS_STAT));
            acc[g].cmd_wr  = wr_en && (reg_addr == BASE + AW'(OFS_CMD));
            acc[g].hold_rd = rd_en && (reg_addr == BASE + AW'(OFS_HOLD));
            acc[g].hold_wr = wr_en && (reg_addr == BASE + AW'(OFS_HOLD));
        end

        assign hold_rd_v[g] = acc[g].hold_rd;
        assign hold_wr_v[g] = acc[g].hold_wr;

        console_channel u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc      (acc[g]),
            .wdata    (reg_wdata),
            .rx_avail (rx_avail[g]),
            .rx_data  (rx_arr[g]),
            .stat_val (stat_val[g]),
            .hold_val (hold_val[g]),
            .tx_data  (tx_arr[g]),
            .tx_valid (tx_valid[g]),
            .flush    (flush[g]),
            .rx_pop   (rx_pop[g])
        );
    end

    console_tick_pacer #(.TICK_DIV(TICK_DIV)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .fire  (tx_fire)
    );

    console_irq_ctrl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_wr (wr_en && (reg_addr == IDX_IRQ)),
        .wdata   (reg_wdata),
        .rx_new  (rx_new),
        .hold_rd (hold_rd_v),
        .hold_wr (hold_wr_v),
        .tx_fire (tx_fire),
        .ack     (acc[0].stat_rd),
        .mask    (mask),
        .isr     (isr),
        .irq     (irq)
    );

    // Read data mux: status, holding and interrupt status; all else zero
    always_comb begin
        reg_rdata = '0;
        if (rd_en) begin
            if (reg_addr == IDX_IRQ) reg_rdata = isr;
            for (int ch = 0; ch < NCH; ch++) begin
                if (acc[ch].stat_rd) reg_rdata = stat_val[ch];
                if (acc[ch].hold_rd) reg_rdata = hold_val[ch];
            end
        end
    end

    AST_STAT_TXRDY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[1].stat_rd) |-> reg_rdata[STAT_TXRDY_BIT]); // R3
    AST_BREAD_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[1].stat_rd && irq) |=> irq); // R4
endmodule

// File: tb/dual_console_irq_test.sv
module dual_console_irq_test;
    localparam logic [2:0] AD_STAT_A = 3'd0, AD_CMD_A = 3'd1, AD_HOLD_A = 3'd2;
    localparam logic [2:0] AD_STAT_B = 3'd3, AD_CMD_B = 3'd4, AD_HOLD_B = 3'd5;
    localparam logic [2:0] AD_IRQ = 3'd6, AD_SPARE = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_en = 1'b0, reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] rx_avail = '0, rx_new = '0;
    logic [7:0] rx_data_a = '0, rx_data_b = '0;
    logic       tick = 1'b0;
    logic [7:0] tx_data_a, tx_data_b;
    logic [1:0] tx_valid, flush, rx_pop;
    logic       irq;

    int checks = 0;
    int failures = 0;
    logic [7:0] rd;

    always #10 clk = ~clk;

    dual_console_irq uut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_avail(rx_avail), .rx_new(rx_new), .rx_data_a(rx_data_a),
        .rx_data_b(rx_data_b), .tick(tick), .tx_data_a(tx_data_a),
        .tx_data_b(tx_data_b), .tx_valid(tx_valid), .flush(flush),
        .rx_pop(rx_pop), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic arrive(input int ch, input logic [7:0] b);
        @(negedge clk);
        if (ch == 0) rx_data_a = b; else rx_data_b = b;
        rx_avail[ch] = 1'b1; rx_new[ch] = 1'b1;
        @(negedge clk);
        rx_new = '0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq after reset", irq, 0);
        bus_read(AD_IRQ, rd);  chk("R1 status after reset", rd, 8'h00);
        bus_read(AD_STAT_A, rd); chk("R3 idle status A", rd, 8'h04);
        arrive(0, 8'h11);
        chk("R1 mask zero: no irq", irq, 0);
        bus_read(AD_IRQ, rd); chk("R2 unmasked arrival no status", rd, 8'h00);
        rx_avail = '0;
    endtask

    task automatic t_receive();
        bus_write(AD_IRQ, 8'h22);
        bus_read(AD_IRQ, rd); chk("R9 read returns status not mask", rd, 8'h00);
        arrive(0, 8'h5A);
        chk("R2 irq raised on A", irq, 1);
        bus_read(AD_IRQ, rd); chk("R2 RX A status", rd, 8'h02);
        bus_read(AD_STAT_A, rd); chk("R3 status A with data", rd, 8'h05);
        chk("R4 A status read drops irq", irq, 0);
        bus_read(AD_HOLD_A, rd); chk("R5 hold A data", rd, 8'h5A);
        chk("R5 rx_pop A", rx_pop, 2'b01);
        rx_avail[0] = 1'b0;
        bus_read(AD_IRQ, rd); chk("R5 RX A cleared", rd, 8'h00);
        arrive(1, 8'hC3);
        chk("R2 irq raised on B", irq, 1);
        bus_read(AD_STAT_B, rd); chk("R3 status B with data", rd, 8'h05);
        chk("R4 B status read keeps irq", irq, 1);
        bus_read(AD_HOLD_B, rd); chk("R5 hold B data", rd, 8'hC3);
        chk("R5 rx_pop B", rx_pop, 2'b10);
        rx_avail[1] = 1'b0;
        bus_read(AD_IRQ, rd); chk("R5 RX B cleared", rd, 8'h00);
        bus_read(AD_STAT_A, rd);
        chk("R4 A read clears irq", irq, 0);
    endtask

    task automatic t_tick();
        bus_write(AD_IRQ, 8'h20);
        pulse_tick(); pulse_tick();
        chk("R7 no TX mask no irq", irq, 0);
        bus_read(AD_IRQ, rd); chk("R7 no TX mask no status", rd, 8'h00);
        bus_write(AD_IRQ, 8'h01);
        pulse_tick();
        chk("R7 first tick after wrap quiet", irq, 0);
        pulse_tick();
        chk("R7 second tick raises irq", irq, 1);
        bus_read(AD_IRQ, rd); chk("R7 both TX bits", rd, 8'h11);
        bus_write(AD_HOLD_B, 8'h77);
        chk("R6 tx_valid B", tx_valid, 2'b10);
        chk("R6 tx_data B", tx_data_b, 8'h77);
        bus_read(AD_IRQ, rd); chk("R6 only TX B cleared", rd, 8'h01);
        bus_write(AD_HOLD_A, 8'h41);
        chk("R6 tx_valid A", tx_valid, 2'b01);
        chk("R6 tx_data A", tx_data_a, 8'h41);
        bus_read(AD_IRQ, rd); chk("R6 TX A cleared", rd, 8'h00);
        bus_read(AD_STAT_A, rd);
        chk("R4 ack after tick irq", irq, 0);
    endtask

    task automatic t_command();
        bus_write(AD_CMD_A, 8'h08); chk("R8 flush A", flush, 2'b01);
        bus_write(AD_CMD_B, 8'h0C); chk("R8 flush B", flush, 2'b10);
        bus_write(AD_CMD_A, 8'h07); chk("R8 no flush without bit3", flush, 2'b00);
        bus_read(AD_CMD_A, rd); chk("R10 command read zero", rd, 8'h00);
    endtask

    task automatic t_spare();
        bus_write(AD_IRQ, 8'h00);
        bus_write(AD_SPARE, 8'hFF);
        bus_read(AD_SPARE, rd); chk("R10 spare reads zero", rd, 8'h00);
        arrive(0, 8'h33);
        chk("R10 spare write left mask clear", irq, 0);
        rx_avail = '0;
    endtask

    task automatic t_collide();
        bus_write(AD_IRQ, 8'h02);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = AD_STAT_A;
        rx_new[0] = 1'b1; rx_avail[0] = 1'b1; rx_data_a = 8'h99;
        @(negedge clk);
        reg_en = 1'b0; rx_new = '0;
        chk("R11 raise beats ack", irq, 1);
        @(negedge clk);
        reg_en = 1'b1; reg_addr = AD_HOLD_A; rx_new[0] = 1'b1;
        @(negedge clk);
        reg_en = 1'b0; rx_new = '0;
        bus_read(AD_IRQ, rd); chk("R11 set beats hold clear", rd, 8'h02);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_receive();
        t_tick();
        t_command();
        t_spare();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule